// File: doc/BRIEF.md
# Address-Flag Serial Receiver with Sleep and Loopback

This block is the receive side of an asynchronous serial link on which several nodes share one line. Each frame carries a flag bit that marks it as either an address or a data frame. When its sleep input is set, a node decodes every frame but delivers only address frames to its data register. Software can therefore ignore data that is meant for other nodes until an address that matches its own arrives. Parity, framing and overrun status keep updating while the node sleeps, so line faults are still reported.

The serial input passes through a loopback selector first. With loopback on, the transmitter's internal bit stream feeds the receiver, the external receive pin is ignored, and the external transmit pin is driven high. The selected line is synchronised and then sampled by a state machine. The sampler uses a bit-rate tick at sixteen times the bit rate and reads each bit at its middle. A register stage then decides whether to load the data and which flags to update.

The sampler moves through four states. From ST_IDLE, a low line on a tick moves it to ST_START (start detect). In ST_START, on the eighth tick the start bit is re-checked at mid-bit. A high line returns to ST_IDLE (false start); a low line moves on to ST_BITS (start confirmed). ST_BITS shifts in ten bits, one every sixteen ticks, and then moves to ST_STOP (payload complete). ST_STOP samples the stop bit at mid-bit, reports the frame, and returns to ST_IDLE (frame end).

Top module: `mpr_receiver`

## Requirements
- R1: A frame is a low start bit, then 8 data bits sent least significant bit first, then the flag bit (1 = address, 0 = data), then an even parity bit covering the data and flag bits, then a high stop bit. With sleep off, every frame loads `rx_data`, copies its flag into `rx_is_addr` and sets `rx_ready`.
- R2: A one-cycle pulse on `rd_strobe` clears `rx_ready` and `oe_flag`.
- R3: With `sleep_en` high, a frame whose flag is 0 leaves `rx_data` and `rx_ready` unchanged. A frame whose flag is 1 loads `rx_data` and sets `rx_ready`.
- R4: Receiving an address frame does not end sleep. Data frames stay blocked until `sleep_en` is driven low, and after that they load again.
- R5: `pe_flag` is updated at the end of every frame, asleep or not. It is 1 when the data, flag and parity bits together contain an odd number of ones, and 0 otherwise.
- R6: `fe_flag` is updated at the end of every frame, asleep or not. It is 1 when the stop bit is sampled low, and 0 otherwise.
- R7: `oe_flag` is set when a frame that loads `rx_data` arrives while `rx_ready` is still 1. The new data replaces the old.
- R8: `err_irq` is high whenever an enabled flag is set, whatever the state of sleep. The enable bits are `err_ie[0]` for parity, `err_ie[1]` for framing and `err_ie[2]` for overrun.
- R9: With `loop_en` high, the receiver decodes `tx_int` and ignores `rx_pin`.
- R10: With `loop_en` high, `tx_pin` is 1. With `loop_en` low, `tx_pin` follows `tx_int`.
- R11: A low pulse that no longer holds low at the middle of the start bit is treated as a false start. It loads nothing and changes no flag.
- R12: During and after reset, `rx_data`, `rx_ready`, `rx_is_addr`, all three flags and `err_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_pin | input | 1 | External serial receive line |
| tx_int | input | 1 | Internal transmit bit stream |
| tx_pin | output | 1 | External transmit line; held high in loopback |
| tick16 | input | 1 | Oversampling tick at sixteen times the bit rate |
| sleep_en | input | 1 | Sleep: deliver only address frames |
| loop_en | input | 1 | Loopback: receive from `tx_int` |
| err_ie | input | 3 | Interrupt enables: [0] parity, [1] framing, [2] overrun |
| rd_strobe | input | 1 | Data register read pulse |
| rx_data | output | 8 | Received data register |
| rx_is_addr | output | 1 | Flag bit of the frame in `rx_data` |
| rx_ready | output | 1 | Unread data present |
| pe_flag | output | 1 | Parity error of the last frame |
| fe_flag | output | 1 | Framing error of the last frame |
| oe_flag | output | 1 | Overrun since the last read |
| err_irq | output | 1 | Error interrupt request |

## Verification
A sampler whose phase or bit count is wrong misplaces a bit. That shows within the same frame as a shifted value in `rx_data` or a wrong parity or framing flag. A sleep gate that lets data frames through, or that clears itself after an address frame, shows as `rx_ready` rising at the end of the next data frame. The stimulus checks this both before and after an address frame. A wrong loopback selection shows as the decoded value of the frame sent on the other line, because `rx_pin` is held low throughout the loopback frame.

// File: rtl/mpr_pkg.sv
package mpr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_BITS,
        ST_STOP
    } rx_state_t;
endpackage

// File: rtl/mpr_line_sel.sv
module mpr_line_sel #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic loop_en,
    input  logic rx_pin,
    input  logic tx_int,
    output logic tx_pin,
    output logic rx_s
);
    logic             line_raw;
    logic [SYNC_STAGES-1:0] sync_q;

    assign line_raw = loop_en ? tx_int : rx_pin;
    assign tx_pin   = loop_en ? 1'b1 : tx_int;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[0] <= 1'b1;
        else        sync_q[0] <= line_raw;
    end

    generate
        for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_sync
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q[g] <= 1'b1;
                else        sync_q[g] <= sync_q[g-1];
            end
        end
    endgenerate

    assign rx_s = sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/mpr_bit_fsm.sv
module mpr_bit_fsm
    import mpr_pkg::*;
#(
    parameter int DATA_BITS = 8,
    parameter int OVS       = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 rx_s,
    output logic                 frame_done,
    output logic [DATA_BITS+1:0] frame_word,
    output logic                 stop_ok
);
    localparam int SHW = DATA_BITS + 2;
    localparam int CW  = $clog2(OVS);
    localparam int IW  = $clog2(SHW + 1);
    localparam logic [CW-1:0] HALF     = CW'(OVS / 2 - 1);
    localparam logic [CW-1:0] LAST     = CW'(OVS - 1);
    localparam logic [IW-1:0] LAST_IDX = IW'(SHW - 1);

    rx_state_t      st, st_n;
    logic [CW-1:0]  cnt;
    logic [IW-1:0]  idx;
    logic [SHW-1:0] sh;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_n;
    end

    // transitions
    always_comb begin
        st_n = st;
        unique case (st)
            ST_IDLE:  if (tick && !rx_s) st_n = ST_START;
            ST_START: if (tick && cnt == HALF) st_n = rx_s ? ST_IDLE : ST_BITS;
            ST_BITS:  if (tick && cnt == LAST && idx == LAST_IDX) st_n = ST_STOP;
            ST_STOP:  if (tick && cnt == LAST) st_n = ST_IDLE;
            default:  st_n = ST_IDLE;
        endcase
    end

    // counters and shift register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            idx <= '0;
            sh  <= '0;
        end else if (tick) begin
            unique case (st)
                ST_IDLE: begin
                    cnt <= '0;
                    idx <= '0;
                end
                ST_START: cnt <= (cnt == HALF) ? '0 : cnt + 1'b1;
                ST_BITS: begin
                    if (cnt == LAST) begin
                        cnt <= '0;
                        sh  <= {rx_s, sh[SHW-1:1]};
                        idx <= idx + 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_STOP: cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
                default: cnt <= '0;
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_done <= 1'b0;
            frame_word <= '0;
            stop_ok    <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            if (tick && st == ST_STOP && cnt == LAST) begin
                frame_done <= 1'b1;
                frame_word <= sh;
                stop_ok    <= rx_s;
            end
        end
    end
endmodule

// File: rtl/mpr_rx_regs.sv
module mpr_rx_regs #(
    parameter int DATA_BITS = 8,
    parameter bit ODD_PAR   = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_done,
    input  logic [DATA_BITS+1:0] frame_word,
    input  logic                 stop_ok,
    input  logic                 sleep_en,
    input  logic                 rd_strobe,
    input  logic [2:0]           err_ie,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_is_addr,
    output logic                 rx_ready,
    output logic                 pe_flag,
    output logic                 fe_flag,
    output logic                 oe_flag,
    output logic                 err_irq
);
    logic flag_bit, par_bad, load;

    assign flag_bit = frame_word[DATA_BITS];
    assign par_bad  = (^frame_word) ^ ODD_PAR;
    assign load     = frame_done && (!sleep_en || flag_bit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data    <= '0;
            rx_is_addr <= 1'b0;
            rx_ready   <= 1'b0;
            pe_flag    <= 1'b0;
            fe_flag    <= 1'b0;
            oe_flag    <= 1'b0;
        end else begin
            if (rd_strobe) begin
                rx_ready <= 1'b0;
                oe_flag  <= 1'b0;
            end
            if (frame_done) begin
                pe_flag <= par_bad;
                fe_flag <= !stop_ok;
            end
            if (load) begin
                rx_data    <= frame_word[DATA_BITS-1:0];
                rx_is_addr <= flag_bit;
                rx_ready   <= 1'b1;
                if (rx_ready && !rd_strobe) oe_flag <= 1'b1;
            end
        end
    end

    assign err_irq = |({oe_flag, fe_flag, pe_flag} & err_ie);
endmodule

// File: rtl/mpr_receiver.sv
module mpr_receiver #(
    parameter int DATA_BITS   = 8,
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2,
    parameter bit ODD_PAR     = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_pin,
    input  logic                 tx_int,
    output logic                 tx_pin,
    input  logic                 tick16,
    input  logic                 sleep_en,
    input  logic                 loop_en,
    input  logic [2:0]           err_ie,
    input  logic                 rd_strobe,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_is_addr,
    output logic                 rx_ready,
    output logic                 pe_flag,
    output logic                 fe_flag,
    output logic                 oe_flag,
    output logic                 err_irq
);
    logic                 rx_s;
    logic                 frame_done;
    logic [DATA_BITS+1:0] frame_word;
    logic                 stop_ok;

    mpr_line_sel #(.SYNC_STAGES(SYNC_STAGES)) u_line (
        .clk(clk), .rst_n(rst_n), .loop_en(loop_en), .rx_pin(rx_pin),
        .tx_int(tx_int), .tx_pin(tx_pin), .rx_s(rx_s)
    );

    mpr_bit_fsm #(.DATA_BITS(DATA_BITS), .OVS(OVS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick16), .rx_s(rx_s),
        .frame_done(frame_done), .frame_word(frame_word), .stop_ok(stop_ok)
    );

    mpr_rx_regs #(.DATA_BITS(DATA_BITS), .ODD_PAR(ODD_PAR)) u_regs (
        .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .frame_word(frame_word),
        .stop_ok(stop_ok), .sleep_en(sleep_en), .rd_strobe(rd_strobe), .err_ie(err_ie),
        .rx_data(rx_data), .rx_is_addr(rx_is_addr), .rx_ready(rx_ready),
        .pe_flag(pe_flag), .fe_flag(fe_flag), .oe_flag(oe_flag), .err_irq(err_irq)
    );
endmodule

// File: rtl/mpr_receiver_chk.sv
module mpr_receiver_chk #(
    parameter int DATA_BITS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sleep_en,
    input logic                 rd_strobe,
    input logic                 frame_done,
    input logic [DATA_BITS+1:0] frame_word,
    input logic                 stop_ok,
    input logic [DATA_BITS-1:0] rx_data,
    input logic                 rx_ready,
    input logic                 fe_flag,
    input logic                 oe_flag
);
    AST_READY_FROM_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ready) |-> $past(frame_done)); // R1

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !frame_done) |=> (!rx_ready && !oe_flag)); // R2

    AST_SLEEP_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && sleep_en && !frame_word[DATA_BITS] && !rd_strobe)
        |=> ($stable(rx_data) && $stable(rx_ready))); // R3

    AST_STOP_TO_FRAMING: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> (fe_flag == !$past(stop_ok))); // R6

    AST_OVERRUN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_flag) |-> $past(frame_done && rx_ready)); // R7
endmodule

bind mpr_receiver mpr_receiver_chk #(.DATA_BITS(DATA_BITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .sleep_en(sleep_en), .rd_strobe(rd_strobe),
    .frame_done(frame_done), .frame_word(frame_word), .stop_ok(stop_ok),
    .rx_data(rx_data), .rx_ready(rx_ready), .fe_flag(fe_flag), .oe_flag(oe_flag)
);

// File: tb/sim_mpr_receiver.sv
module sim_mpr_receiver;
    localparam int BIT_CLK = 32; // tick every other cycle, 16 ticks per bit

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_pin = 1'b1;
    logic       tx_int = 1'b1;
    logic       tx_pin;
    logic       tick16 = 1'b0;
    logic       sleep_en = 1'b0;
    logic       loop_en = 1'b0;
    logic [2:0] err_ie = 3'b000;
    logic       rd_strobe = 1'b0;
    logic [7:0] rx_data;
    logic       rx_is_addr, rx_ready, pe_flag, fe_flag, oe_flag, err_irq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;
    always_ff @(posedge clk) tick16 <= ~tick16;

    mpr_receiver u0 (
        .clk(clk), .rst_n(rst_n), .rx_pin(rx_pin), .tx_int(tx_int), .tx_pin(tx_pin),
        .tick16(tick16), .sleep_en(sleep_en), .loop_en(loop_en), .err_ie(err_ie),
        .rd_strobe(rd_strobe), .rx_data(rx_data), .rx_is_addr(rx_is_addr),
        .rx_ready(rx_ready), .pe_flag(pe_flag), .fe_flag(fe_flag), .oe_flag(oe_flag),
        .err_irq(err_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive_bit(input logic b, input bit via_loop);
        if (via_loop) tx_int = b;
        else          rx_pin = b;
        repeat (BIT_CLK) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input logic flag, input bit bad_par,
                              input bit bad_stop, input bit via_loop);
        logic p;
        p = (^{flag, d}) ^ bad_par;
        drive_bit(1'b0, via_loop);
        for (int i = 0; i < 8; i++) drive_bit(d[i], via_loop);
        drive_bit(flag, via_loop);
        drive_bit(p, via_loop);
        drive_bit(!bad_stop, via_loop);
        for (int i = 0; i < 3; i++) drive_bit(1'b1, via_loop);
    endtask

    task automatic do_read();
        @(negedge clk) rd_strobe = 1'b1;
        @(negedge clk) rd_strobe = 1'b0;
    endtask

    task automatic t_reset();
        chk("R12 data", rx_data, 0);
        chk("R12 ready", rx_ready, 0);
        chk("R12 addr", rx_is_addr, 0);
        chk("R12 flags", {pe_flag, fe_flag, oe_flag}, 0);
        chk("R12 irq", err_irq, 0);
        chk("R10 tx follows idle", tx_pin, 1);
    endtask

    task automatic t_normal();
        send_frame(8'hA5, 1'b0, 0, 0, 0);
        chk("R1 data A5", rx_data, 8'hA5);
        chk("R1 ready", rx_ready, 1);
        chk("R1 addr flag 0", rx_is_addr, 0);
        chk("R5 R6 clean frame", {pe_flag, fe_flag}, 0);
        do_read();
        chk("R2 ready cleared", rx_ready, 0);
        send_frame(8'h3C, 1'b1, 0, 0, 0);
        chk("R1 data 3C", rx_data, 8'h3C);
        chk("R1 addr flag 1", rx_is_addr, 1);
        do_read();
    endtask

    task automatic t_overrun();
        err_ie = 3'b100;
        send_frame(8'h11, 1'b0, 0, 0, 0);
        chk("R7 no overrun yet", oe_flag, 0);
        send_frame(8'h22, 1'b0, 0, 0, 0);
        chk("R7 overrun set", oe_flag, 1);
        chk("R7 new data kept", rx_data, 8'h22);
        chk("R8 overrun irq", err_irq, 1);
        do_read();
        chk("R2 overrun cleared", oe_flag, 0);
        chk("R2 ready cleared after overrun", rx_ready, 0);
        chk("R8 irq drops", err_irq, 0);
        err_ie = 3'b000;
    endtask

    task automatic t_sleep();
        sleep_en = 1'b1;
        send_frame(8'h55, 1'b0, 0, 0, 0);
        chk("R3 data frame not loaded", rx_data, 8'h22);
        chk("R3 ready stays low", rx_ready, 0);
        send_frame(8'h81, 1'b1, 0, 0, 0);
        chk("R3 address loaded", rx_data, 8'h81);
        chk("R3 address ready", rx_ready, 1);
        do_read();
        send_frame(8'h66, 1'b0, 0, 0, 0);
        chk("R4 still asleep data", rx_data, 8'h81);
        chk("R4 still asleep ready", rx_ready, 0);
        sleep_en = 1'b0;
        send_frame(8'h66, 1'b0, 0, 0, 0);
        chk("R4 awake loads", rx_data, 8'h66);
        chk("R4 awake ready", rx_ready, 1);
        do_read();
    endtask

    task automatic t_errors_asleep();
        sleep_en = 1'b1;
        err_ie = 3'b001;
        send_frame(8'h0F, 1'b0, 1, 0, 0);
        chk("R5 parity flag asleep", pe_flag, 1);
        chk("R8 parity irq asleep", err_irq, 1);
        chk("R3 bad frame not loaded", rx_ready, 0);
        @(negedge clk) err_ie = 3'b000;
        @(negedge clk);
        chk("R8 masked irq", err_irq, 0);
        err_ie = 3'b010;
        send_frame(8'hF0, 1'b0, 0, 1, 0);
        chk("R6 framing flag asleep", fe_flag, 1);
        chk("R5 parity cleared next frame", pe_flag, 0);
        chk("R8 framing irq", err_irq, 1);
        send_frame(8'h5A, 1'b0, 0, 0, 0);
        chk("R6 framing cleared", fe_flag, 0);
        chk("R8 irq cleared", err_irq, 0);
        err_ie = 3'b000;
        sleep_en = 1'b0;
    endtask

    task automatic t_loop();
        @(negedge clk) loop_en = 1'b1;
        rx_pin = 1'b0;
        tx_int = 1'b0;
        @(negedge clk);
        chk("R10 tx high in loop", tx_pin, 1);
        tx_int = 1'b1;
        repeat (BIT_CLK) @(negedge clk);
        send_frame(8'hC3, 1'b0, 0, 0, 1);
        chk("R9 loop data", rx_data, 8'hC3);
        chk("R9 loop ready", rx_ready, 1);
        chk("R9 loop clean", fe_flag, 0);
        do_read();
        rx_pin = 1'b1;
        repeat (4) @(negedge clk);
        loop_en = 1'b0;
        tx_int = 1'b0;
        @(negedge clk);
        chk("R10 tx follows out of loop", tx_pin, 0);
        tx_int = 1'b1;
        repeat (BIT_CLK) @(negedge clk);
    endtask

    task automatic t_false_start();
        rx_pin = 1'b0;
        repeat (8) @(negedge clk);
        rx_pin = 1'b1;
        repeat (6 * BIT_CLK) @(negedge clk);
        chk("R11 no load", rx_ready, 0);
        chk("R11 data kept", rx_data, 8'hC3);
        chk("R11 flags kept", {pe_flag, fe_flag, oe_flag}, 0);
        send_frame(8'h99, 1'b0, 0, 0, 0);
        chk("R11 next frame ok", rx_data, 8'h99);
        do_read();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_normal();
        t_overrun();
        t_sleep();
        t_errors_asleep();
        t_loop();
        t_false_start();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog all requirements: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule